// File: doc/BRIEF.md
# Add/Subtract Unit with Flag-Based Condition Evaluation

This block is a purely combinational two's-complement adder-subtractor of parameterised width (32 bits by default). A subtract control picks between the sum A+B and the difference A−B. The difference is formed by adding the bitwise inverse of B with a carry-in of one. The same logic serves signed and unsigned operands. Alongside the result the block drives four condition flags: zero, negative, carry and overflow.

A second section turns a 4-bit condition selector into a single compare bit. It does not compare magnitudes directly. It always works from the flags of the difference A−B, with separate decode rules for signed and unsigned ordering. For this reason a second subtraction path runs in parallel. When the subtract control is low, the result and flag outputs still show A+B, while the compare bit still reflects A−B. The carry chain is built either as a bit-level ripple or from the synthesis tool's adder, chosen by a parameter.

Top module: `addsub_cond`

## Requirements
- R1: With `sub_en`=0, `result` equals (A + B) mod 2^WIDTH.
- R2: With `sub_en`=1, `result` equals (A + ~B + 1) mod 2^WIDTH, which is A − B.
- R3: `flag_z` is 1 exactly when every bit of `result` is 0.
- R4: `flag_n` equals the most significant bit of `result`.
- R5: `flag_c` is the carry out of the most significant position of the addition performed. For subtraction, 1 means no borrow (A ≥ B unsigned).
- R6: `flag_v` is 1 exactly when both adder inputs (A, and B or ~B) have the same sign and `result` has the other sign.
- R7: Selector code 0 gives A == B, and code 1 gives A != B.
- R8: Signed ordering: code 2 gives A < B, code 3 gives A <= B, code 4 gives A >= B, and code 5 gives A > B. These are decoded as N^V, Z|(N^V), ~(N^V) and ~(Z|(N^V)).
- R9: Unsigned ordering: code 6 gives A < B, code 7 gives A <= B, code 8 gives A >= B, and code 9 gives A > B. These are decoded as ~C, ~C|Z, C and C&~Z.
- R10: Selector codes 10 through 15 drive `cond_out` to 0.
- R11: `cond_out` always comes from the flags of A − B, whatever `sub_en` is. Only `result` and the flag outputs follow `sub_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand A |
| op_b | input | WIDTH | Second operand B |
| sub_en | input | 1 | 1 selects A − B, 0 selects A + B |
| cond_sel | input | 4 | Condition selector code |
| result | output | WIDTH | Sum or difference |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| flag_c | output | 1 | Carry out of the MSB |
| flag_v | output | 1 | Signed overflow |
| cond_out | output | 1 | Selected compare outcome of A − B |

## Verification
The bound checker watches every input change. It checks that zero and negative agree with the result bits, that an unsigned add carries exactly when the result wraps below A, and that overflow follows the sign rule for same-sign addends. It also checks that codes 10–15 stay low and that equality in subtract mode matches the zero flag. Only the bench's scenarios can confirm the arithmetic value itself, every signed and unsigned ordering code against true comparisons, and the split where the add path drives the flags while the compare bit follows the difference. Those scenarios include the sign boundaries 0x7FFFFFFF and 0x80000000, wrap-around at all ones, and equal operands.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [3:0] {
        COND_EQ  = 4'd0,
        COND_NE  = 4'd1,
        COND_LT  = 4'd2,
        COND_LE  = 4'd3,
        COND_GE  = 4'd4,
        COND_GT  = 4'd5,
        COND_LTU = 4'd6,
        COND_LEU = 4'd7,
        COND_GEU = 4'd8,
        COND_GTU = 4'd9
    } cond_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    localparam int CARRY_RIPPLE = 0;
    localparam int CARRY_TOOL   = 1;

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int WIDTH       = 32,
    parameter int CARRY_STYLE = 0
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_msb_in,
    output logic             carry_out
);
    import addsub_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    assign b_eff = b_in ^ {WIDTH{sub_in}};

    generate
        if (CARRY_STYLE == CARRY_RIPPLE) begin : g_ripple
            logic [WIDTH:0] chain;
            assign chain[0] = sub_in;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                logic prop;
                assign prop         = a_in[i] ^ b_eff[i];
                assign sum_out[i]   = prop ^ chain[i];
                assign chain[i+1]   = (a_in[i] & b_eff[i]) | (chain[i] & prop);
            end
            assign carry_msb_in = chain[MSB];
            assign carry_out    = chain[WIDTH];
        end else begin : g_tool
            logic [WIDTH:0] full;
            logic [MSB:0]   low;
            assign full = {1'b0, a_in} + {1'b0, b_eff} + (WIDTH+1)'(sub_in);
            assign low  = {1'b0, a_in[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]} + WIDTH'(sub_in);
            assign sum_out      = full[MSB:0];
            assign carry_msb_in = low[MSB];
            assign carry_out    = full[WIDTH];
        end
    endgenerate

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]      sum_in,
    input  logic                  carry_msb_in,
    input  logic                  carry_out,
    output addsub_pkg::flags_t    flags_out
);
    import addsub_pkg::*;

    localparam int MSB = WIDTH - 1;

    flags_t flags_d;

    always_comb begin
        flags_d   = '0;
        flags_d.z = ~|sum_in;
        flags_d.n = sum_in[MSB];
        flags_d.c = carry_out;
        flags_d.v = carry_msb_in ^ carry_out;
    end

    assign flags_out = flags_d;

endmodule

// File: rtl/addsub_cond_decode.sv
module addsub_cond_decode (
    input  addsub_pkg::flags_t flags_in,
    input  logic [3:0]         sel_in,
    output logic               cond_out
);
    import addsub_pkg::*;

    logic lt_d;
    logic le_d;
    logic ltu_d;
    logic leu_d;
    logic hit_d;

    always_comb begin
        lt_d  = flags_in.n ^ flags_in.v;
        le_d  = flags_in.z | lt_d;
        ltu_d = ~flags_in.c;
        leu_d = ltu_d | flags_in.z;
        case (sel_in)
            COND_EQ:  hit_d = flags_in.z;
            COND_NE:  hit_d = ~flags_in.z;
            COND_LT:  hit_d = lt_d;
            COND_LE:  hit_d = le_d;
            COND_GE:  hit_d = ~lt_d;
            COND_GT:  hit_d = ~le_d;
            COND_LTU: hit_d = ltu_d;
            COND_LEU: hit_d = leu_d;
            COND_GEU: hit_d = flags_in.c;
            COND_GTU: hit_d = ~leu_d;
            default:  hit_d = 1'b0;
        endcase
    end

    assign cond_out = hit_d;

endmodule

// File: rtl/addsub_cond.sv
module addsub_cond #(
    parameter int WIDTH       = 32,
    parameter int CARRY_STYLE = 0
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_en,
    input  logic [3:0]       cond_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v,
    output logic             cond_out
);
    import addsub_pkg::*;

    logic [WIDTH-1:0] main_sum;
    logic             main_cin_msb;
    logic             main_cout;
    flags_t           main_flags;

    logic [WIDTH-1:0] cmp_sum;
    logic             cmp_cin_msb;
    logic             cmp_cout;
    flags_t           cmp_flags;

    // Path that follows sub_en and feeds the visible result and flags.
    addsub_core #(.WIDTH(WIDTH), .CARRY_STYLE(CARRY_STYLE)) u_main_core (
        .a_in         (op_a),
        .b_in         (op_b),
        .sub_in       (sub_en),
        .sum_out      (main_sum),
        .carry_msb_in (main_cin_msb),
        .carry_out    (main_cout)
    );

    addsub_flags #(.WIDTH(WIDTH)) u_main_flags (
        .sum_in       (main_sum),
        .carry_msb_in (main_cin_msb),
        .carry_out    (main_cout),
        .flags_out    (main_flags)
    );

    // Path that always subtracts; feeds only the condition decoder.
    addsub_core #(.WIDTH(WIDTH), .CARRY_STYLE(CARRY_STYLE)) u_cmp_core (
        .a_in         (op_a),
        .b_in         (op_b),
        .sub_in       (1'b1),
        .sum_out      (cmp_sum),
        .carry_msb_in (cmp_cin_msb),
        .carry_out    (cmp_cout)
    );

    addsub_flags #(.WIDTH(WIDTH)) u_cmp_flags (
        .sum_in       (cmp_sum),
        .carry_msb_in (cmp_cin_msb),
        .carry_out    (cmp_cout),
        .flags_out    (cmp_flags)
    );

    addsub_cond_decode u_decode (
        .flags_in (cmp_flags),
        .sel_in   (cond_sel),
        .cond_out (cond_out)
    );

    assign result = main_sum;
    assign flag_z = main_flags.z;
    assign flag_n = main_flags.n;
    assign flag_c = main_flags.c;
    assign flag_v = main_flags.v;

endmodule

// File: rtl/addsub_cond_chk.sv
module addsub_cond_chk #(
    parameter int WIDTH       = 32,
    parameter int CARRY_STYLE = 0
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_en,
    input logic [3:0]       cond_sel,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_n,
    input logic             flag_c,
    input logic             flag_v,
    input logic             cond_out
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        assert_zero_flag_R3: assert (flag_z == (result == '0))
            else $error("zero flag disagrees with result");
        assert_sign_flag_R4: assert (flag_n == result[MSB])
            else $error("negative flag disagrees with result MSB");
        assert_add_carry_R5: assert (sub_en || (flag_c == (result < op_a)))
            else $error("add carry does not match unsigned wrap");
        assert_add_overflow_R6: assert (sub_en || (op_a[MSB] != op_b[MSB])
                                        || (flag_v == (result[MSB] != op_a[MSB])))
            else $error("add overflow does not follow sign rule");
        assert_bad_code_R10: assert ((cond_sel < 4'd10) || !cond_out)
            else $error("undefined selector produced a 1");
        assert_eq_tracks_z_R11: assert (!sub_en || (cond_sel != 4'd0) || (cond_out == flag_z))
            else $error("equality in subtract mode differs from zero flag");
    end

endmodule

bind addsub_cond addsub_cond_chk #(.WIDTH(WIDTH), .CARRY_STYLE(CARRY_STYLE)) u_chk (.*);

// File: tb/addsub_cond_bench.sv
module addsub_cond_bench;

    localparam int W = 32;

    typedef struct {
        logic [W-1:0] res;
        logic         z, n, c, v, cnd;
        logic         sub;
        logic [3:0]   sel;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_en = 1'b0;
    logic [3:0]   cond_sel = 4'd0;
    logic [W-1:0] result;
    logic         flag_z, flag_n, flag_c, flag_v, cond_out;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    addsub_cond u_addsub_cond (
        .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .cond_sel(cond_sel),
        .result(result), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v), .cond_out(cond_out)
    );

    function automatic logic expect_cond(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s);
        case (s)
            4'd0: return a == b;                 // R7
            4'd1: return a != b;                 // R7
            4'd2: return $signed(a) <  $signed(b); // R8
            4'd3: return $signed(a) <= $signed(b);
            4'd4: return $signed(a) >= $signed(b);
            4'd5: return $signed(a) >  $signed(b);
            4'd6: return a <  b;                 // R9
            4'd7: return a <= b;
            4'd8: return a >= b;
            4'd9: return a >  b;
            default: return 1'b0;                // R10
        endcase
    endfunction

    function automatic string cond_tag(logic [3:0] s, logic sub);
        string t;
        if (s < 4'd2) t = "R7";
        else if (s < 4'd6) t = "R8";
        else if (s < 4'd10) t = "R9";
        else t = "R10";
        if (!sub) t = {t, "/R11"};
        return t;
    endfunction

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic sub, logic [3:0] s);
        exp_t         e;
        logic [W-1:0] bx;
        logic [W:0]   full;
        bx    = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, bx} + (W+1)'(sub);
        e.res = full[W-1:0];
        e.c   = full[W];
        e.z   = (e.res == '0);
        e.n   = e.res[W-1];
        e.v   = (a[W-1] == bx[W-1]) && (e.res[W-1] != a[W-1]);
        e.cnd = expect_cond(a, b, s);
        e.sub = sub;
        e.sel = s;
        @(posedge clk);
        op_a = a; op_b = b; sub_en = sub; cond_sel = s;
        sb_q.push_back(e);
    endtask

    task automatic sweep(logic [W-1:0] a, logic [W-1:0] b, logic sub);
        for (int s = 0; s < 16; s++) drive(a, b, sub, 4'(s));
    endtask

    task automatic cmp1(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b a=%h b=%h sub=%0b sel=%0d",
                     tag, act, exp, op_a, op_b, sub_en, cond_sel);
        end
    endtask

    // Monitor: compare the design's outputs at the falling edge
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res) begin
                errors++;
                $display("FAIL %s act=%h exp=%h", e.sub ? "R2" : "R1", result, e.res);
            end
            cmp1(flag_z, e.z, "R3");
            cmp1(flag_n, e.n, "R4");
            cmp1(flag_c, e.c, "R5");
            cmp1(flag_v, e.v, "R6");
            cmp1(cond_out, e.cnd, cond_tag(e.sel, e.sub));
        end
    end

    initial begin
        logic [W-1:0] seed;
        seed = 32'h1234_5678;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state inputs: all zero, zero flag set (R3)
        drive('0, '0, 1'b0, 4'd0);
        sweep(32'd5, 32'd3, 1'b0);                    // R1, R11
        sweep(32'd1, 32'hFFFF_FFFF, 1'b0);            // R1 wrap, R5 carry
        sweep(32'h7FFF_FFFF, 32'd1, 1'b0);            // R6 positive overflow
        sweep(32'h8000_0000, 32'h8000_0000, 1'b0);    // R6 negative overflow
        sweep(32'd5, 32'd5, 1'b1);                    // R2, R7 equal
        sweep(32'd3, 32'd5, 1'b1);                    // R2 borrow
        sweep(32'h8000_0000, 32'd1, 1'b1);            // R6 sub overflow
        sweep(32'd0, 32'd1, 1'b1);                    // R5 borrow
        sweep(32'hFFFF_FFFF, 32'd1, 1'b1);            // R8 vs R9 disagree
        sweep(32'd1, 32'hFFFF_FFFF, 1'b0);            // R11 compare via sub
        sweep(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);    // R8 boundary
        for (int k = 0; k < 24; k++) begin
            logic [W-1:0] ra, rb;
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
            ra = seed;
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
            rb = (k % 4 == 0) ? ra : seed;
            sweep(ra, rb, 1'(k % 2));
        end
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule